// File: doc/BRIEF.md
# Serial Debug Command Controller

This block sits between a serial debug front end and an embedded microcontroller with on-chip flash. The front end delivers pairs of a 4-bit slot code and a 4-bit value. The block loads each value into one nibble of three working registers: a 16-bit data register, a 16-bit address register and a 4-bit command register. It also keeps a separate 4-bit mode register.

Writing the command register starts one operation. The operation may be a CPU port read or write, a flash byte read or write, a page or partition erase, a read of the accumulator or program counter, or a CPU control action: halt, release, single step, program-counter clear or module reset. Port and flash operations use request/acknowledge handshakes. CPU control actions are one-cycle pulses. Most commands may only run while the CPU is halted. A command that is refused for this reason sets a sticky error flag instead of running.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: Slot codes 0,1,2,3 load the value into data-register bits [3:0],[7:4],[11:8],[15:12]. Codes 4,5,6,7 load the same slices of the address register. The new value is visible one cycle after the write.
- R2: Code 8 loads the command register. `busy` is high from the cycle after that write until the operation completes. Code 9 loads the mode register. Codes 10 to 15 change no register.
- R3: While `busy` is high, writes with codes 0 to 8 are dropped, and the data, address and command registers are kept. Code 9 is still accepted.
- R4: Command 0 drives `port_req` with `port_we`=1, `port_sel` = address[3:0] and `port_wdata` = data. Command 2 reads the port at address[3:0] into the data register. Both commands run while the CPU is running.
- R5: While `cpu_port_busy` is high, `port_req` stays low. The debug port access waits and is issued once the CPU releases the ports.
- R6: Command 1 writes data[7:0] to flash with `fl_op`=1. Command 3 reads flash with `fl_op`=0 into data[7:0] and leaves data[15:8] unchanged.
- R7: Command 4 copies `cpu_acc` into the data register. Command 6 copies `cpu_pc` into the data register. Command 5 reads flash at address `cpu_pc`[11:0] into data[7:0].
- R8: In the cycle after the command write, commands 7,8,9,10,11 raise exactly one of `halt_req`, `run_req`, `step_req`, `pc_clr`, `mod_rst` for one cycle. Command 12 raises none of them.
- R9: Command 13 requests `fl_op`=2 at address[11:6] with the six low address bits at zero. Command 14 requests `fl_op`=3 at address zero.
- R10: Command 15 sets `aux_sel`, which drives `fl_aux`. The next halt command (7) clears it.
- R11: While `aux_sel` is set, `fl_addr` bits [11:7] are zero. Otherwise all 12 address bits pass through.
- R12: Commands 1,3,4,5,6,8,9,10,11,13,14,15 issued while `cpu_halted` is low are not executed and set `err`. Any accepted command write clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Slot write strobe from the serial front end |
| wr_addr | input | 4 | Slot code |
| wr_data | input | 4 | Nibble value |
| hold_data | output | 16 | Data register |
| addr_reg | output | 16 | Address register |
| mode_reg | output | 4 | Mode register |
| busy | output | 1 | Command in progress |
| err | output | 1 | Sticky refused-command flag |
| aux_sel | output | 1 | Auxiliary flash partition selected |
| cpu_halted | input | 1 | CPU halted status |
| cpu_acc | input | 16 | CPU accumulator |
| cpu_pc | input | 16 | CPU program counter |
| halt_req | output | 1 | Halt pulse |
| run_req | output | 1 | Release-halt pulse |
| step_req | output | 1 | Single-step pulse |
| pc_clr | output | 1 | Program-counter clear pulse |
| mod_rst | output | 1 | Module/flash controller/register reset pulse |
| cpu_port_busy | input | 1 | CPU is using the ports this cycle |
| port_req | output | 1 | Port access request |
| port_we | output | 1 | Port access is a write |
| port_sel | output | 4 | Port number |
| port_wdata | output | 16 | Port write data |
| port_rdata | input | 16 | Port read data |
| port_ack | input | 1 | Port access done |
| fl_req | output | 1 | Flash request |
| fl_op | output | 2 | 0 read, 1 write, 2 page erase, 3 partition erase |
| fl_aux | output | 1 | Request targets the auxiliary partition |
| fl_addr | output | 12 | Flash byte address |
| fl_wdata | output | 8 | Flash write byte |
| fl_rdata | input | 8 | Flash read byte |
| fl_ack | input | 1 | Flash operation done |

## Verification
The assertions assume that `port_ack` and `fl_ack` arrive only while the matching request is high and last one cycle. They also assume that `cpu_port_busy` changes only while no port acknowledge is pending. The bench responders meet these assumptions. Each responder acknowledges on the first sampled cycle of a request and drops the acknowledge as soon as the request falls. `cpu_port_busy` and `cpu_halted` are changed only while the block is idle or waiting for a grant.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        FL_READ       = 2'd0,
        FL_WRITE      = 2'd1,
        FL_PAGE_ERASE = 2'd2,
        FL_PART_ERASE = 2'd3
    } fl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_PORT,
        ST_FLASH
    } st_e;

    typedef enum logic [3:0] {
        C_PORT_WR  = 4'd0,
        C_FL_WR    = 4'd1,
        C_PORT_RD  = 4'd2,
        C_FL_RD    = 4'd3,
        C_ACC_RD   = 4'd4,
        C_PC_FL_RD = 4'd5,
        C_PC_RD    = 4'd6,
        C_HALT     = 4'd7,
        C_RUN      = 4'd8,
        C_STEP     = 4'd9,
        C_PC_CLR   = 4'd10,
        C_MOD_RST  = 4'd11,
        C_NOP      = 4'd12,
        C_PAGE_ER  = 4'd13,
        C_PART_ER  = 4'd14,
        C_AUX_SEL  = 4'd15
    } cmd_e;

    // bit n set: command n needs a halted CPU
    localparam logic [15:0] HALT_ONLY = 16'hEF7A;
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_cmd_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int MW = 4,
    parameter int BW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CODE_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              lock,
    input  logic              ld_full,
    input  logic              ld_low,
    input  logic [DW-1:0]     ld_val,
    output logic [DW-1:0]     data_q,
    output logic [AW-1:0]     addr_q,
    output logic [MW-1:0]     mode_q,
    output logic              cmd_wr,
    output logic [CODE_W-1:0] cmd_val
);
    localparam int NIB       = CODE_W;
    localparam int DSL       = DW / NIB;
    localparam int ASL       = AW / NIB;
    localparam int DATA_BASE = 0;
    localparam int ADDR_BASE = DATA_BASE + DSL;
    localparam int CMD_CODE  = ADDR_BASE + ASL;
    localparam int MODE_CODE = CMD_CODE + 1;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
        logic [MW-1:0] mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < DSL; i++) begin
            if (wr_valid && !lock && wr_addr == CODE_W'(DATA_BASE + i))
                r_d.data[i*NIB +: NIB] = wr_data;
        end
        for (int j = 0; j < ASL; j++) begin
            if (wr_valid && !lock && wr_addr == CODE_W'(ADDR_BASE + j))
                r_d.addr[j*NIB +: NIB] = wr_data;
        end
        if (wr_valid && wr_addr == CODE_W'(MODE_CODE))
            r_d.mode = wr_data[MW-1:0];
        if (ld_full)
            r_d.data = ld_val;
        else if (ld_low)
            r_d.data[BW-1:0] = ld_val[BW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_q  = r_q.data;
    assign addr_q  = r_q.addr;
    assign mode_q  = r_q.mode;
    assign cmd_wr  = wr_valid && !lock && wr_addr == CODE_W'(CMD_CODE);
    assign cmd_val = wr_data;

    assert_lock_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_valid) |=> $stable(addr_q));
    assert_ignore_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr > CODE_W'(MODE_CODE) && !ld_full && !ld_low)
        |=> ($stable(data_q) && $stable(addr_q) && $stable(mode_q)));
endmodule

// File: rtl/dbg_port_gate.sv
module dbg_port_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic cpu_busy,
    output logic port_req
);
    assign port_req = want && !cpu_busy;

    // a blocked debug access must keep asking
    assert_debug_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (want && cpu_busy) |=> want);
endmodule

// File: rtl/dbg_dispatch.sv
module dbg_dispatch
    import dbg_cmd_pkg::*;
#(
    parameter int DW        = 16,
    parameter int FAW       = 12,
    parameter int AUX_AW    = 7,
    parameter int PAGE_BITS = 6,
    parameter int BW        = 8,
    parameter int PSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CODE_W-1:0] cmd_val,
    input  logic [DW-1:0]     data_q,
    input  logic [FAW-1:0]    fa_in,
    input  logic              cpu_halted,
    input  logic [DW-1:0]     cpu_acc,
    input  logic [DW-1:0]     cpu_pc,
    input  logic [DW-1:0]     port_rdata,
    input  logic              port_ack,
    input  logic [BW-1:0]     fl_rdata,
    input  logic              fl_ack,
    output logic              busy,
    output logic              err,
    output logic              aux_sel,
    output logic              port_want,
    output logic              port_we,
    output logic [PSEL_W-1:0] port_sel,
    output logic [DW-1:0]     port_wdata,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [FAW-1:0]    fl_addr,
    output logic [BW-1:0]     fl_wdata,
    output logic              halt_req,
    output logic              run_req,
    output logic              step_req,
    output logic              pc_clr,
    output logic              mod_rst,
    output logic              ld_full,
    output logic              ld_low,
    output logic [DW-1:0]     ld_val
);
    localparam logic [FAW-1:0] AUX_MASK =
        {{(FAW-AUX_AW){1'b0}}, {AUX_AW{1'b1}}};

    typedef struct packed {
        st_e  st;
        cmd_e cmd;
        logic err;
        logic aux;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [FAW-1:0] fa_base;
    logic           is_read;

    always_comb begin
        c_d       = c_q;
        port_want = 1'b0;
        fl_req    = 1'b0;
        halt_req  = 1'b0;
        run_req   = 1'b0;
        step_req  = 1'b0;
        pc_clr    = 1'b0;
        mod_rst   = 1'b0;
        ld_full   = 1'b0;
        ld_low    = 1'b0;
        ld_val    = '0;
        is_read   = (c_q.cmd == C_FL_RD) || (c_q.cmd == C_PC_FL_RD);

        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    c_d.cmd = cmd_e'(cmd_val);
                    c_d.err = 1'b0;
                    c_d.st  = ST_EXEC;
                end
            end
            ST_EXEC: begin
                c_d.st = ST_IDLE;
                if (HALT_ONLY[c_q.cmd] && !cpu_halted) begin
                    c_d.err = 1'b1;
                end else begin
                    unique case (c_q.cmd)
                        C_PORT_WR, C_PORT_RD: c_d.st = ST_PORT;
                        C_FL_WR, C_FL_RD, C_PC_FL_RD,
                        C_PAGE_ER, C_PART_ER: c_d.st = ST_FLASH;
                        C_ACC_RD: begin ld_full = 1'b1; ld_val = cpu_acc; end
                        C_PC_RD:  begin ld_full = 1'b1; ld_val = cpu_pc;  end
                        C_HALT:   begin halt_req = 1'b1; c_d.aux = 1'b0; end
                        C_RUN:    run_req  = 1'b1;
                        C_STEP:   step_req = 1'b1;
                        C_PC_CLR: pc_clr   = 1'b1;
                        C_MOD_RST: mod_rst = 1'b1;
                        C_AUX_SEL: c_d.aux = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_PORT: begin
                port_want = 1'b1;
                if (port_ack) begin
                    c_d.st = ST_IDLE;
                    if (c_q.cmd == C_PORT_RD) begin
                        ld_full = 1'b1;
                        ld_val  = port_rdata;
                    end
                end
            end
            ST_FLASH: begin
                fl_req = 1'b1;
                if (fl_ack) begin
                    c_d.st = ST_IDLE;
                    if (is_read) begin
                        ld_low = 1'b1;
                        ld_val = {{(DW-BW){1'b0}}, fl_rdata};
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        fa_base = (c_q.cmd == C_PC_FL_RD) ? cpu_pc[FAW-1:0] : fa_in;
        if (c_q.cmd == C_PAGE_ER) fa_base[PAGE_BITS-1:0] = '0;
        if (c_q.cmd == C_PART_ER) fa_base = '0;
        fl_addr = fa_base & (c_q.aux ? AUX_MASK : {FAW{1'b1}});
        unique case (c_q.cmd)
            C_FL_WR:   fl_op = FL_WRITE;
            C_PAGE_ER: fl_op = FL_PAGE_ERASE;
            C_PART_ER: fl_op = FL_PART_ERASE;
            default:   fl_op = FL_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cmd: C_NOP, err: 1'b0, aux: 1'b0};
        else        c_q <= c_d;
    end

    assign busy       = (c_q.st != ST_IDLE);
    assign err        = c_q.err;
    assign aux_sel    = c_q.aux;
    assign port_we    = (c_q.cmd == C_PORT_WR);
    assign port_sel   = fa_in[PSEL_W-1:0];
    assign port_wdata = data_q;
    assign fl_wdata   = data_q[BW-1:0];

    assert_busy_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> busy);
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, run_req, step_req, pc_clr, mod_rst}));
    assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_want && fl_req));
    assert_aux_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && aux_sel) |-> (fl_addr[FAW-1:AUX_AW] == '0));
    assert_halt_clears_aux_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !aux_sel);
    assert_no_err_on_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> !err);
    assert_port_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ack && busy) |-> port_want);
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dbg_cmd_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 16,
    parameter int MW        = 4,
    parameter int FAW       = 12,
    parameter int AUX_AW    = 7,
    parameter int PAGE_BITS = 6,
    parameter int BW        = 8,
    parameter int PSEL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [3:0]        wr_addr,
    input  logic [3:0]        wr_data,
    output logic [DW-1:0]     hold_data,
    output logic [AW-1:0]     addr_reg,
    output logic [MW-1:0]     mode_reg,
    output logic              busy,
    output logic              err,
    output logic              aux_sel,
    input  logic              cpu_halted,
    input  logic [DW-1:0]     cpu_acc,
    input  logic [DW-1:0]     cpu_pc,
    output logic              halt_req,
    output logic              run_req,
    output logic              step_req,
    output logic              pc_clr,
    output logic              mod_rst,
    input  logic              cpu_port_busy,
    output logic              port_req,
    output logic              port_we,
    output logic [PSEL_W-1:0] port_sel,
    output logic [DW-1:0]     port_wdata,
    input  logic [DW-1:0]     port_rdata,
    input  logic              port_ack,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic              fl_aux,
    output logic [FAW-1:0]    fl_addr,
    output logic [BW-1:0]     fl_wdata,
    input  logic [BW-1:0]     fl_rdata,
    input  logic              fl_ack
);
    logic              cmd_wr;
    logic [CODE_W-1:0] cmd_val;
    logic              ld_full, ld_low;
    logic [DW-1:0]     ld_val;
    logic              port_want;

    dbg_regs #(.DW(DW), .AW(AW), .MW(MW), .BW(BW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock(busy), .ld_full(ld_full), .ld_low(ld_low), .ld_val(ld_val),
        .data_q(hold_data), .addr_q(addr_reg), .mode_q(mode_reg),
        .cmd_wr(cmd_wr), .cmd_val(cmd_val)
    );

    dbg_dispatch #(.DW(DW), .FAW(FAW), .AUX_AW(AUX_AW), .PAGE_BITS(PAGE_BITS),
                   .BW(BW), .PSEL_W(PSEL_W)) u_disp (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_val(cmd_val),
        .data_q(hold_data), .fa_in(addr_reg[FAW-1:0]),
        .cpu_halted(cpu_halted), .cpu_acc(cpu_acc), .cpu_pc(cpu_pc),
        .port_rdata(port_rdata), .port_ack(port_ack),
        .fl_rdata(fl_rdata), .fl_ack(fl_ack),
        .busy(busy), .err(err), .aux_sel(aux_sel),
        .port_want(port_want), .port_we(port_we), .port_sel(port_sel),
        .port_wdata(port_wdata),
        .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .halt_req(halt_req), .run_req(run_req), .step_req(step_req),
        .pc_clr(pc_clr), .mod_rst(mod_rst),
        .ld_full(ld_full), .ld_low(ld_low), .ld_val(ld_val)
    );

    dbg_port_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .want(port_want), .cpu_busy(cpu_port_busy), .port_req(port_req)
    );

    assign fl_aux = aux_sel;
endmodule

// File: tb/tb_dbg_cmd_ctrl.sv
module tb_dbg_cmd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        wr_valid = 0;
    logic [3:0]  wr_addr = 0, wr_data = 0;
    logic [15:0] hold_data, addr_reg;
    logic [3:0]  mode_reg;
    logic        busy, err, aux_sel;
    logic        cpu_halted = 0;
    logic [15:0] cpu_acc = 0, cpu_pc = 0;
    logic        halt_req, run_req, step_req, pc_clr, mod_rst;
    logic        cpu_port_busy = 0;
    logic        port_req, port_we;
    logic [3:0]  port_sel;
    logic [15:0] port_wdata, port_rdata;
    logic        port_ack = 0;
    logic        fl_req, fl_aux;
    logic [1:0]  fl_op;
    logic [11:0] fl_addr;
    logic [7:0]  fl_wdata, fl_rdata;
    logic        fl_ack = 0;

    dbg_cmd_ctrl dut (.*);

    assign port_rdata = 16'hC0DE ^ {12'h000, port_sel};
    assign fl_rdata   = fl_addr[7:0] ^ 8'h5A;

    int compared = 0, mismatched = 0, cycles = 0;
    int n_port = 0, n_fl = 0, n_halt = 0;
    logic        r_pwe;
    logic [3:0]  r_psel;
    logic [15:0] r_pwd;
    logic [1:0]  r_fop;
    logic [11:0] r_fadr;
    logic [7:0]  r_fwd;
    logic        r_faux;

    always @(negedge clk) begin
        port_ack <= port_req && !port_ack;
        fl_ack   <= fl_req && !fl_ack;
        if (port_req && !port_ack) begin
            n_port++; r_pwe <= port_we; r_psel <= port_sel; r_pwd <= port_wdata;
        end
        if (fl_req && !fl_ack) begin
            n_fl++; r_fop <= fl_op; r_fadr <= fl_addr; r_fwd <= fl_wdata; r_faux <= fl_aux;
        end
        if (halt_req) n_halt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            $display("FAIL watchdog expired");
            mismatched++;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_valid = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    endtask

    task automatic set_addr(input logic [15:0] v);
        for (int k = 0; k < 4; k++) wr(4'(4 + k), v[k*4 +: 4]);
    endtask

    // {code, value, expected data, expected address, expected mode}
    localparam logic [43:0] VEC [0:11] = '{
        {4'd0,  4'h1, 16'h0001, 16'h0000, 4'h0},
        {4'd1,  4'h2, 16'h0021, 16'h0000, 4'h0},
        {4'd2,  4'h3, 16'h0321, 16'h0000, 4'h0},
        {4'd3,  4'h4, 16'h4321, 16'h0000, 4'h0},
        {4'd4,  4'h5, 16'h4321, 16'h0005, 4'h0},
        {4'd5,  4'h6, 16'h4321, 16'h0065, 4'h0},
        {4'd6,  4'h7, 16'h4321, 16'h0765, 4'h0},
        {4'd7,  4'h8, 16'h4321, 16'h8765, 4'h0},
        {4'd9,  4'hA, 16'h4321, 16'h8765, 4'hA},
        {4'd10, 4'hF, 16'h4321, 16'h8765, 4'hA},
        {4'd14, 4'h3, 16'h4321, 16'h8765, 4'hA},
        {4'd15, 4'h1, 16'h4321, 16'h8765, 4'hA}
    };

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        chk("R2 reset busy", 16'(busy), 16'h0);
        chk("R12 reset err", 16'(err), 16'h0);
        chk("R1 reset data", hold_data, 16'h0);
        chk("R10 reset aux", 16'(aux_sel), 16'h0);
        rst_n = 1;

        // R1 / R2 slot loading walk
        foreach (VEC[i]) begin
            wr(VEC[i][43:40], VEC[i][39:36]);
            chk($sformatf("R1 data v%0d", i), hold_data, VEC[i][35:20]);
            chk($sformatf("R1 addr v%0d", i), addr_reg, VEC[i][19:4]);
            chk($sformatf("R2 mode v%0d", i), 16'(mode_reg), 16'(VEC[i][3:0]));
        end

        // R4 port write while running
        wr(8, 4'd0);
        chk("R2 busy after cmd", 16'(busy), 16'h1);
        wait_idle();
        chk("R4 port write we/sel", {11'h0, r_pwe, r_psel}, 16'h0015);
        chk("R4 port wdata", r_pwd, 16'h4321);
        chk("R4 no err running", 16'(err), 16'h0);
        // R4 port read
        wr(8, 4'd2); wait_idle();
        chk("R4 port read data", hold_data, 16'hC0DB);

        // R5 CPU priority, plus R3 dropped writes while busy
        cpu_port_busy = 1;
        p0 = n_port;
        wr(8, 4'd2);
        wr(4, 4'hF);
        wr(8, 4'd7);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R5 port_req held off", 16'(port_req), 16'h0);
        end
        chk("R5 still busy", 16'(busy), 16'h1);
        chk("R3 address kept", addr_reg, 16'h8765);
        cpu_port_busy = 0;
        wait_idle();
        chk("R5 access issued after release", 16'(n_port - p0), 16'h1);
        chk("R3 dropped halt", 16'(n_halt), 16'h0);

        // R12 gated command while running
        p0 = n_fl;
        wr(8, 4'd3); wait_idle();
        chk("R12 err set", 16'(err), 16'h1);
        chk("R12 no flash req", 16'(n_fl - p0), 16'h0);
        chk("R12 data kept", hold_data, 16'hC0DB);

        // R8 halt, R12 clear
        wr(8, 4'd7);
        chk("R8 halt pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0010);
        wait_idle();
        chk("R12 err cleared", 16'(err), 16'h0);
        cpu_halted = 1;

        // R10 aux select, R11 mask, R6 write/read
        wr(8, 4'hF); wait_idle();
        chk("R10 aux set", 16'(aux_sel), 16'h1);
        set_addr(16'h0FFF);
        wr(0, 4'hC); wr(1, 4'h3);
        wr(8, 4'd1); wait_idle();
        chk("R6 flash write op", 16'(r_fop), 16'h1);
        chk("R11 aux masked addr", 16'(r_fadr), 16'h007F);
        chk("R6 flash wdata", 16'(r_fwd), 16'h003C);
        chk("R10 fl_aux", 16'(r_faux), 16'h1);
        wr(8, 4'd3); wait_idle();
        chk("R6 flash read low byte", hold_data, 16'hC025);
        wr(8, 4'd7); wait_idle();
        chk("R10 halt clears aux", 16'(aux_sel), 16'h0);
        wr(8, 4'd3); wait_idle();
        chk("R11 main full addr", 16'(r_fadr), 16'h0FFF);
        chk("R6 read main", hold_data, 16'hC0A5);

        // R9 erases
        wr(8, 4'hD); wait_idle();
        chk("R9 page op", 16'(r_fop), 16'h2);
        chk("R9 page addr", 16'(r_fadr), 16'h0FC0);
        wr(8, 4'hE); wait_idle();
        chk("R9 part op", 16'(r_fop), 16'h3);
        chk("R9 part addr", 16'(r_fadr), 16'h0000);

        // R7 acc, pc, flash at pc
        cpu_acc = 16'h1234; cpu_pc = 16'h0ABC;
        wr(8, 4'd4); wait_idle();
        chk("R7 acc read", hold_data, 16'h1234);
        wr(8, 4'd6); wait_idle();
        chk("R7 pc read", hold_data, 16'h0ABC);
        wr(8, 4'd5); wait_idle();
        chk("R7 flash at pc addr", 16'(r_fadr), 16'h0ABC);
        chk("R7 flash at pc data", hold_data, 16'h0AE6);

        // R8 remaining pulses
        wr(8, 4'd8);
        chk("R8 run pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0008);
        wait_idle();
        wr(8, 4'd9);
        chk("R8 step pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0004);
        wait_idle();
        wr(8, 4'hA);
        chk("R8 pc clear pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0002);
        wait_idle();
        wr(8, 4'hB);
        chk("R8 module reset pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0001);
        wait_idle();
        wr(8, 4'hC);
        chk("R8 nop no pulse", {11'h0, halt_req, run_req, step_req, pc_clr, mod_rst}, 16'h0000);
        wait_idle();
        chk("R8 nop done", 16'(busy), 16'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule